// File: doc/BRIEF.md
# Scoreboard Hazard Control Unit

This block is the central issue and hazard controller of a small out-of-order core that has several functional units. Each cycle the front end may present one decoded instruction. The instruction carries an operation class, a destination register and two source registers. The controller keeps one status slot for each functional unit and one pending-writer tag for each architectural register. With these it decides three things: when an instruction may issue, when each unit may fetch its operands from the register file, and when each unit may write its result back. The units themselves sit outside the block. Each unit starts on a read grant and, some cycles later, reports completion with a one-cycle done pulse.

Issue is in order. It stops on a busy unit and on a destination that already has a pending writer. Operands are read only from the register file, and a value becomes readable in the cycle after its producer is granted write-back. A unit that has finished waits to write while any other unit still has an unread, ready operand that names the same register. Units may complete and write back in any order.

Top module: `sb_hazard_ctrl`

## Requirements
- R1: After synchronous active-low reset, every unit is free and every register has no pending writer. With no request present, `stall`, `issue_fu`, `read_go` and `write_go` are all zero and `unit_op` is zero. A request then issues without a stall.
- R2: Operation classes map to units as follows. `in_op` 0 (memory) goes to unit 0 and `in_op` 1 (add) goes to unit 1. `in_op` 2 and 3 (multiply class) go to the lowest-numbered free multiplier unit among units 2 and 3. The grant appears on `issue_fu` as a one-hot vector in the same cycle as the request. From the next cycle until write-back, `unit_op[2*u+1:2*u]` holds the operation code of unit u.
- R3: If every unit of the requested class is busy, `stall` is 1 and `issue_fu` is zero in that cycle.
- R4: If the requested destination register has a pending writer, `stall` is 1. This includes the cycle in which that writer is granted write-back. The request issues in the cycle after that write-back.
- R5: A source register with no pending writer at issue counts as ready. If both sources are ready, `read_go` for the unit is 1 in the cycle after issue.
- R6: A source that has a pending writer is not forwarded. `read_go` stays 0 until the cycle after the producer's `write_go`.
- R7: A `fu_done` pulse for an executing unit leads to that unit's `write_go` in the next cycle, provided that no write-after-read conflict exists.
- R8: A finished unit's `write_go` is held while another busy unit has a ready, not yet read source equal to its destination. It is granted in the cycle after that reader's `read_go`.
- R9: Write-back order follows completion order and not issue order. A later-issued unit that finishes first writes first.
- R10: Each issued instruction receives exactly one `read_go` and one `write_go`. A `fu_done` pulse for a unit that is not executing has no effect.
- R11: If an instruction issues in the same cycle that the producer of one of its sources is granted `write_go`, that source counts as ready. `read_go` then follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Decoded instruction present |
| in_op | input | 2 | Operation code: 0 memory, 1 add, 2/3 multiply class |
| in_dst | input | 3 | Destination register |
| in_src1 | input | 3 | First source register |
| in_src2 | input | 3 | Second source register |
| fu_done | input | 4 | Per-unit execution-complete pulse |
| stall | output | 1 | Request present but not issued this cycle |
| issue_fu | output | 4 | One-hot unit receiving the instruction |
| read_go | output | 4 | Per-unit operand read grant (also the unit start) |
| write_go | output | 4 | Per-unit result write-back grant |
| unit_op | output | 8 | Operation code held by each unit, two bits per unit |

## Verification
The checker watches a set of properties on every cycle. Issue grants are one-hot or zero and never go to a busy unit. A stall never carries a grant, and a pending destination always stalls. A unit is free after its write-back and busy after its issue, and it never receives two read grants in a row. Cycle-exact latencies can only be shown by the bench's directed scenarios. Those include the wake-up cycle after a producer writes, write-back held behind an unread old value, out-of-order completion, same-cycle issue against a finishing producer, and ignored done pulses.

// File: rtl/sb_pkg.sv
// Shared types for the scoreboard hazard controller.
// Assumes two-bit operation codes; the top bit marks the multiply class.
package sb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // slot free
        ST_WAIT = 2'd1,   // issued, waiting for operands
        ST_EXEC = 2'd2,   // operands read, unit running
        ST_DONE = 2'd3    // result ready, waiting to write
    } slot_state_e;

    localparam logic [1:0] OPC_MEM = 2'd0;
    localparam logic [1:0] OPC_ADD = 2'd1;

endpackage

// File: rtl/sb_unit_pick.sv
// Chooses the functional unit for an incoming operation.
// Unit 0 serves memory ops, unit 1 adds, units 2 and up the multiply class;
// the lowest free candidate wins. Purely combinational.
module sb_unit_pick
    import sb_pkg::*;
#(
    parameter int N_FU = 4
) (
    input  logic [1:0]      op,
    input  logic [N_FU-1:0] busy,
    output logic [N_FU-1:0] pick
);

    logic [N_FU-1:0] cand;

    // Candidate mask per operation class
    always_comb begin
        cand = '0;
        for (int u = 0; u < N_FU; u++) begin
            if (u == 0)      cand[u] = (op == OPC_MEM);
            else if (u == 1) cand[u] = (op == OPC_ADD);
            else             cand[u] = op[1];
        end
    end

    // Lowest free candidate, one-hot
    always_comb begin
        logic found;
        found = 1'b0;
        pick  = '0;
        for (int u = 0; u < N_FU; u++) begin
            if (!found && cand[u] && !busy[u]) begin
                pick[u] = 1'b1;
                found   = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sb_result_table.sv
// Register result-status table: one pending-writer tag per register.
// Tag 0 means no pending writer; tag u+1 names unit u.
// Assumes set and clear never target the same register in one cycle.
module sb_result_table #(
    parameter int N_REG = 8,
    parameter int RW    = 3,
    parameter int TW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [RW-1:0]    set_reg,
    input  logic [TW-1:0]    set_tag,
    input  logic [N_REG-1:0] clr_mask,
    input  logic [RW-1:0]    rd_a,
    input  logic [RW-1:0]    rd_b,
    input  logic [RW-1:0]    rd_d,
    output logic [TW-1:0]    tag_a,
    output logic [TW-1:0]    tag_b,
    output logic [TW-1:0]    tag_d
);

    logic [TW-1:0] tags [N_REG];

    // Record new writers at issue, drop them at write-back
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < N_REG; r++) tags[r] <= '0;
        end else begin
            for (int r = 0; r < N_REG; r++) begin
                if (set_en && set_reg == RW'(r)) tags[r] <= set_tag;
                else if (clr_mask[r])            tags[r] <= '0;
            end
        end
    end

    // Combinational lookups for the request
    always_comb begin
        tag_a = tags[rd_a];
        tag_b = tags[rd_b];
        tag_d = tags[rd_d];
    end

endmodule

// File: rtl/sb_fu_slot.sv
// Status slot of one functional unit: busy state, operation, destination,
// source numbers, producer tags and ready flags. Wakes on a matching
// write-back and grants its own read and write steps.
// Assumes issue is only asserted while the slot is idle.
module sb_fu_slot
    import sb_pkg::*;
#(
    parameter int N_FU = 4,
    parameter int RW   = 3,
    parameter int TW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue,
    input  logic [1:0]      op_in,
    input  logic [RW-1:0]   dst_in,
    input  logic [RW-1:0]   s1_in,
    input  logic [RW-1:0]   s2_in,
    input  logic [TW-1:0]   q1_in,
    input  logic [TW-1:0]   q2_in,
    input  logic            r1_in,
    input  logic            r2_in,
    input  logic [N_FU-1:0] wake,
    input  logic            done,
    input  logic            war_hold,
    output logic            busy,
    output logic            read_go,
    output logic            write_go,
    output logic [1:0]      op,
    output logic [RW-1:0]   dst,
    output logic [RW-1:0]   s1,
    output logic [RW-1:0]   s2,
    output logic            r1,
    output logic            r2
);

    slot_state_e   st;
    logic [TW-1:0] q1, q2;
    logic          hit1, hit2;

    // Producer write-back matches either awaited tag
    always_comb begin
        hit1 = 1'b0;
        hit2 = 1'b0;
        for (int g = 0; g < N_FU; g++) begin
            if (wake[g] && q1 == TW'(g + 1)) hit1 = 1'b1;
            if (wake[g] && q2 == TW'(g + 1)) hit2 = 1'b1;
        end
    end

    // Step grants
    always_comb begin
        busy     = (st != ST_IDLE);
        read_go  = (st == ST_WAIT) && r1 && r2;
        write_go = (st == ST_DONE) && !war_hold;
    end

    // Slot state and field updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            op  <= '0;
            dst <= '0;
            s1  <= '0;
            s2  <= '0;
            q1  <= '0;
            q2  <= '0;
            r1  <= 1'b0;
            r2  <= 1'b0;
        end else if (issue) begin
            st  <= ST_WAIT;
            op  <= op_in;
            dst <= dst_in;
            s1  <= s1_in;
            s2  <= s2_in;
            q1  <= q1_in;
            q2  <= q2_in;
            r1  <= r1_in;
            r2  <= r2_in;
        end else begin
            if (hit1) begin
                q1 <= '0;
                r1 <= 1'b1;
            end
            if (hit2) begin
                q2 <= '0;
                r2 <= 1'b1;
            end
            case (st)
                ST_WAIT: if (read_go) begin
                    r1 <= 1'b0;
                    r2 <= 1'b0;
                    st <= ST_EXEC;
                end
                ST_EXEC: if (done) st <= ST_DONE;
                ST_DONE: if (write_go) begin
                    st  <= ST_IDLE;
                    op  <= '0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sb_hazard_ctrl.sv
// Scoreboard hazard controller: in-order issue with structural and
// write-after-write stalls, operand read once both sources are valid in
// the register file, and write-back held against write-after-read.
// Assumes external units start on read_go and pulse fu_done once.
module sb_hazard_ctrl #(
    parameter int N_REG = 8,
    parameter int N_MUL = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [1:0]                 in_op,
    input  logic [$clog2(N_REG)-1:0]   in_dst,
    input  logic [$clog2(N_REG)-1:0]   in_src1,
    input  logic [$clog2(N_REG)-1:0]   in_src2,
    input  logic [N_MUL+1:0]           fu_done,
    output logic                       stall,
    output logic [N_MUL+1:0]           issue_fu,
    output logic [N_MUL+1:0]           read_go,
    output logic [N_MUL+1:0]           write_go,
    output logic [2*(N_MUL+2)-1:0]     unit_op
);

    localparam int N_FU = N_MUL + 2;
    localparam int RW   = $clog2(N_REG);
    localparam int TW   = $clog2(N_FU + 1);

    logic [N_FU-1:0]  fu_busy, pick, war_hold;
    logic [TW-1:0]    tag_a, tag_b, tag_d, new_tag, q1_new, q2_new;
    logic             r1_new, r2_new, dst_pend, can_issue;
    logic [N_REG-1:0] clr_mask;
    logic [1:0]       slot_op  [N_FU];
    logic [RW-1:0]    slot_dst [N_FU];
    logic [RW-1:0]    slot_s1  [N_FU];
    logic [RW-1:0]    slot_s2  [N_FU];
    logic             slot_r1  [N_FU];
    logic             slot_r2  [N_FU];

    sb_unit_pick #(.N_FU(N_FU)) u_pick (
        .op   (in_op),
        .busy (fu_busy),
        .pick (pick)
    );

    sb_result_table #(.N_REG(N_REG), .RW(RW), .TW(TW)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (can_issue),
        .set_reg  (in_dst),
        .set_tag  (new_tag),
        .clr_mask (clr_mask),
        .rd_a     (in_src1),
        .rd_b     (in_src2),
        .rd_d     (in_dst),
        .tag_a    (tag_a),
        .tag_b    (tag_b),
        .tag_d    (tag_d)
    );

    // Issue decision: free unit of the class and no pending destination writer
    always_comb begin
        dst_pend  = (tag_d != '0);
        can_issue = in_valid && (|pick) && !dst_pend;
        stall     = in_valid && !can_issue;
        issue_fu  = can_issue ? pick : '0;
    end

    // Tag of the chosen unit
    always_comb begin
        new_tag = '0;
        for (int g = 0; g < N_FU; g++) begin
            if (pick[g]) new_tag = TW'(g + 1);
        end
    end

    // Source readiness at issue; a producer writing this cycle counts as done
    always_comb begin
        r1_new = (tag_a == '0);
        r2_new = (tag_b == '0);
        for (int g = 0; g < N_FU; g++) begin
            if (write_go[g] && tag_a == TW'(g + 1)) r1_new = 1'b1;
            if (write_go[g] && tag_b == TW'(g + 1)) r2_new = 1'b1;
        end
        q1_new = r1_new ? '0 : tag_a;
        q2_new = r2_new ? '0 : tag_b;
    end

    // Write-after-read hold: another unit still owes a read of the old value
    always_comb begin
        war_hold = '0;
        for (int f = 0; f < N_FU; f++) begin
            for (int g = 0; g < N_FU; g++) begin
                if (g != f && fu_busy[g] &&
                    ((slot_r1[g] && slot_s1[g] == slot_dst[f]) ||
                     (slot_r2[g] && slot_s2[g] == slot_dst[f])))
                    war_hold[f] = 1'b1;
            end
        end
    end

    // Registers released by this cycle's write-backs
    always_comb begin
        clr_mask = '0;
        for (int f = 0; f < N_FU; f++) begin
            if (write_go[f]) clr_mask[slot_dst[f]] = 1'b1;
        end
    end

    for (genvar f = 0; f < N_FU; f++) begin : g_slot
        sb_fu_slot #(.N_FU(N_FU), .RW(RW), .TW(TW)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .issue    (issue_fu[f]),
            .op_in    (in_op),
            .dst_in   (in_dst),
            .s1_in    (in_src1),
            .s2_in    (in_src2),
            .q1_in    (q1_new),
            .q2_in    (q2_new),
            .r1_in    (r1_new),
            .r2_in    (r2_new),
            .wake     (write_go),
            .done     (fu_done[f]),
            .war_hold (war_hold[f]),
            .busy     (fu_busy[f]),
            .read_go  (read_go[f]),
            .write_go (write_go[f]),
            .op       (slot_op[f]),
            .dst      (slot_dst[f]),
            .s1       (slot_s1[f]),
            .s2       (slot_s2[f]),
            .r1       (slot_r1[f]),
            .r2       (slot_r2[f])
        );
        assign unit_op[2*f +: 2] = slot_op[f];
    end

endmodule

// File: rtl/sb_hazard_ctrl_chk.sv
// Protocol checker for sb_hazard_ctrl, attached by bind.
// Assumes synchronous active-low reset; all checks are off during reset.
module sb_hazard_ctrl_chk #(
    parameter int N_FU = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            stall,
    input logic            dst_pend,
    input logic [N_FU-1:0] issue_fu,
    input logic [N_FU-1:0] read_go,
    input logic [N_FU-1:0] write_go,
    input logic [N_FU-1:0] fu_busy
);

    // R2
    issue_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(issue_fu));

    // R3
    issue_free_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_fu & fu_busy) == '0);

    // R3
    stall_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (issue_fu == '0));

    // R4
    waw_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dst_pend) |-> stall);

    for (genvar u = 0; u < N_FU; u++) begin : g_unit
        // R10
        single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
            read_go[u] |=> !read_go[u]);

        // R10
        free_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            write_go[u] |=> !fu_busy[u]);

        // R2
        busy_after_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
            issue_fu[u] |=> fu_busy[u]);
    end

endmodule

bind sb_hazard_ctrl sb_hazard_ctrl_chk #(.N_FU(N_FU)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .stall    (stall),
    .dst_pend (dst_pend),
    .issue_fu (issue_fu),
    .read_go  (read_go),
    .write_go (write_go),
    .fu_busy  (fu_busy)
);

// File: tb/test_sb_hazard_ctrl.sv
// Bench for sb_hazard_ctrl: a vector table for class mapping and
// structural stalls, then directed hazard scenarios.
module test_sb_hazard_ctrl;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] in_op = '0;
    logic [2:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
    logic [3:0] fu_done = '0;
    logic       stall;
    logic [3:0] issue_fu, read_go, write_go;
    logic [7:0] unit_op;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sb_hazard_ctrl i_sb_hazard_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_op    (in_op),
        .in_dst   (in_dst),
        .in_src1  (in_src1),
        .in_src2  (in_src2),
        .fu_done  (fu_done),
        .stall    (stall),
        .issue_fu (issue_fu),
        .read_go  (read_go),
        .write_go (write_go),
        .unit_op  (unit_op)
    );

    // {valid, op, dst, src1, src2, expected issue_fu, expected stall}
    localparam logic [16:0] VECS [6] = '{
        {1'b1, 2'd0, 3'd0, 3'd6, 3'd7, 4'b0001, 1'b0},
        {1'b1, 2'd1, 3'd1, 3'd6, 3'd7, 4'b0010, 1'b0},
        {1'b1, 2'd2, 3'd2, 3'd6, 3'd7, 4'b0100, 1'b0},
        {1'b1, 2'd3, 3'd3, 3'd6, 3'd7, 4'b1000, 1'b0},
        {1'b1, 2'd2, 3'd4, 3'd6, 3'd7, 4'b0000, 1'b1},
        {1'b1, 2'd1, 3'd5, 3'd6, 3'd7, 4'b0000, 1'b1}
    };

    // Compare and count one result
    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // Advance to the drive/sample point just after the next rising edge
    task automatic nxt();
        @(posedge clk);
        #2;
    endtask

    task automatic req(input logic v, input logic [1:0] op,
                       input logic [2:0] d, input logic [2:0] a, input logic [2:0] b);
        in_valid = v;
        in_op    = op;
        in_dst   = d;
        in_src1  = a;
        in_src2  = b;
    endtask

    task automatic do_reset();
        req(1'b0, 2'd0, 3'd0, 3'd0, 3'd0);
        fu_done = '0;
        rst_n   = 1'b0;
        nxt();
        nxt();
        rst_n = 1'b1;
        #1;
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        chk("R1", "stall", {7'd0, stall}, 8'd0);
        chk("R1", "issue_fu", {4'd0, issue_fu}, 8'd0);
        chk("R1", "read_go", {4'd0, read_go}, 8'd0);
        chk("R1", "write_go", {4'd0, write_go}, 8'd0);
        chk("R1", "unit_op", unit_op, 8'd0);
        req(1'b1, 2'd0, 3'd0, 3'd1, 3'd2);
        #1;
        chk("R1", "first request stall", {7'd0, stall}, 8'd0);

        // R2 / R3 vector table
        do_reset();
        for (int i = 0; i < 6; i++) begin
            req(VECS[i][16], VECS[i][15:14], VECS[i][13:11], VECS[i][10:8], VECS[i][7:5]);
            #1;
            chk(VECS[i][0] ? "R3" : "R2", "issue_fu", {4'd0, issue_fu}, {4'd0, VECS[i][4:1]});
            chk(VECS[i][0] ? "R3" : "R2", "stall", {7'd0, stall}, {7'd0, VECS[i][0]});
            nxt();
        end
        req(1'b0, 2'd0, 3'd0, 3'd0, 3'd0);
        #1;
        chk("R2", "unit_op per unit", unit_op, 8'b11_10_01_00);

        // R5, R6, R7: multiply r1, then add reading r1
        do_reset();
        req(1'b1, 2'd2, 3'd1, 3'd6, 3'd7);
        nxt();
        req(1'b1, 2'd1, 3'd2, 3'd1, 3'd7);
        #1;
        chk("R6", "dependent add issues", {4'd0, issue_fu}, 8'b0010);
        chk("R5", "ready read next cycle", {4'd0, read_go}, 8'b0100);
        nxt();
        req(1'b0, 2'd0, 3'd0, 3'd0, 3'd0);
        fu_done = 4'b0100;
        #1;
        chk("R6", "add waits for r1", {4'd0, read_go}, 8'd0);
        nxt();
        fu_done = '0;
        #1;
        chk("R7", "write after done", {4'd0, write_go}, 8'b0100);
        chk("R6", "no forwarding", {4'd0, read_go}, 8'd0);
        nxt();
        #1;
        chk("R6", "read after producer write", {4'd0, read_go}, 8'b0010);
        nxt();
        fu_done = 4'b0010;
        nxt();
        fu_done = '0;
        #1;
        chk("R7", "add writes", {4'd0, write_go}, 8'b0010);

        // R4 WAW stall
        do_reset();
        req(1'b1, 2'd1, 3'd3, 3'd6, 3'd7);
        nxt();
        req(1'b1, 2'd2, 3'd3, 3'd6, 3'd7);
        #1;
        chk("R4", "pending dst stalls", {7'd0, stall}, 8'd1);
        nxt();
        fu_done = 4'b0010;
        #1;
        chk("R4", "still stalled", {7'd0, stall}, 8'd1);
        nxt();
        fu_done = '0;
        #1;
        chk("R4", "writer granted", {4'd0, write_go}, 8'b0010);
        chk("R4", "stall during write", {7'd0, stall}, 8'd1);
        nxt();
        #1;
        chk("R4", "released stall", {7'd0, stall}, 8'd0);
        chk("R4", "issues after write", {4'd0, issue_fu}, 8'b0100);
        nxt();
        req(1'b0, 2'd0, 3'd0, 3'd0, 3'd0);

        // R8 WAR hold
        do_reset();
        req(1'b1, 2'd0, 3'd6, 3'd7, 3'd7);
        nxt();
        req(1'b1, 2'd2, 3'd5, 3'd6, 3'd3);
        nxt();
        req(1'b1, 2'd1, 3'd3, 3'd7, 3'd7);
        #1;
        chk("R8", "writer of r3 issues", {4'd0, issue_fu}, 8'b0010);
        nxt();
        req(1'b0, 2'd0, 3'd0, 3'd0, 3'd0);
        #1;
        chk("R8", "add reads", {4'd0, read_go}, 8'b0010);
        nxt();
        fu_done = 4'b0010;
        nxt();
        fu_done = 4'b0001;
        #1;
        chk("R8", "write held by old reader", {4'd0, write_go}, 8'd0);
        nxt();
        fu_done = '0;
        #1;
        chk("R8", "load writes, add held", {4'd0, write_go}, 8'b0001);
        nxt();
        #1;
        chk("R8", "reader takes old r3", {4'd0, read_go}, 8'b0100);
        chk("R8", "still held on read cycle", {4'd0, write_go}, 8'd0);
        nxt();
        #1;
        chk("R8", "write released", {4'd0, write_go}, 8'b0010);

        // R9 out-of-order completion
        do_reset();
        req(1'b1, 2'd2, 3'd1, 3'd6, 3'd7);
        nxt();
        req(1'b1, 2'd1, 3'd2, 3'd6, 3'd7);
        nxt();
        req(1'b0, 2'd0, 3'd0, 3'd0, 3'd0);
        nxt();
        fu_done = 4'b0010;
        nxt();
        fu_done = 4'b0100;
        #1;
        chk("R9", "later add writes first", {4'd0, write_go}, 8'b0010);
        nxt();
        fu_done = '0;
        #1;
        chk("R9", "earlier multiply writes last", {4'd0, write_go}, 8'b0100);

        // R11 issue against a finishing producer
        do_reset();
        req(1'b1, 2'd1, 3'd2, 3'd6, 3'd7);
        nxt();
        req(1'b0, 2'd0, 3'd0, 3'd0, 3'd0);
        nxt();
        fu_done = 4'b0010;
        nxt();
        fu_done = '0;
        req(1'b1, 2'd2, 3'd5, 3'd2, 3'd7);
        #1;
        chk("R11", "producer writing", {4'd0, write_go}, 8'b0010);
        chk("R11", "consumer issues", {4'd0, issue_fu}, 8'b0100);
        nxt();
        req(1'b0, 2'd0, 3'd0, 3'd0, 3'd0);
        #1;
        chk("R11", "consumer reads next cycle", {4'd0, read_go}, 8'b0100);

        // R10 stray done pulses and single write-back
        do_reset();
        fu_done = 4'b1111;
        nxt();
        fu_done = '0;
        req(1'b1, 2'd0, 3'd0, 3'd6, 3'd7);
        #1;
        chk("R10", "stray done ignored", {4'd0, write_go}, 8'd0);
        chk("R10", "unit still free", {4'd0, issue_fu}, 8'b0001);
        nxt();
        req(1'b0, 2'd0, 3'd0, 3'd0, 3'd0);
        #1;
        chk("R10", "single read", {4'd0, read_go}, 8'b0001);
        nxt();
        fu_done = 4'b0001;
        nxt();
        fu_done = '0;
        #1;
        chk("R10", "single write", {4'd0, write_go}, 8'b0001);
        nxt();
        #1;
        chk("R10", "no second write", {4'd0, write_go}, 8'd0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule